// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one start request into the sequence of column addresses that an SDRAM burst visits, one address per clock. The controller gives it a starting column, a burst length code, a wrap-order bit, the device organisation and the direction of the access. The block then steps through the burst, marking every beat with a valid strobe and the final beat with a last flag. Programming of the mode register, command sequencing and data-path timing all sit in other blocks.

Wrap order can be linear within an aligned block or bit-interleaved. A full-page burst walks the whole row and wraps at the row end, and it stops only when a new start or a stop request arrives. An option turns every write into a single beat while reads keep their programmed length. The organisation selector narrows the column range, and the column bits that a device does not use are driven to zero. A start request is accepted on any clock and replaces any burst in progress.

Top module: `sdram_col_gen`

## Requirements
- R1: The clock edge that samples `start_i` high puts beat 0 on the outputs: `valid_o`=1 and `col_o` is `start_col_i` with unused bits cleared.
- R2: Sequential order (`wrap_il_i`=0) with length L in {2,4,8}: beat k carries the upper column bits of the start unchanged, and low log2(L) bits equal to (start low bits + k) mod L.
- R3: Interleaved order (`wrap_il_i`=1) with length L in {2,4,8}: beat k has low log2(L) bits equal to (start low bits XOR k), and the upper bits are unchanged.
- R4: Length code 7 selects full page. Beat k is (start + k) mod page size, with page size 1024, 512 or 256 for x4, x8 or x16. The order is always sequential, even when `wrap_il_i`=1. `last_o` never rises, and the burst runs until a stop or a new start.
- R5: Length codes are 0→1, 1→2, 2→4 and 3→8 beats. `last_o` is high on beat L-1 only (on beat 0 when L=1), and on the next clock `valid_o` is 0 unless a start is sampled.
- R6: When `wr_single_i`=1 and `is_write_i`=1 at start, the burst is one beat long with `last_o`=1. Reads, and writes with `wr_single_i`=0, keep the programmed length.
- R7: `org_i` 0 = x4 uses 10 column bits, 1 = x8 uses 9 bits (bit 9 is 0), and 2 or 3 = x16 uses 8 bits (bits 9:8 are 0).
- R8: A start sampled while a burst is active drops that burst and begins the new one on the next clock.
- R9: When `stop_i` is sampled during a burst and no start is sampled on the same edge, `valid_o` and `last_o` are 0 from the next clock on.
- R10: After reset, and whenever no beat is valid, `valid_o`=0, `last_o`=0 and `col_o`=0.
- R11: Length codes 4, 5 and 6 are reserved and give a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a new burst |
| start_col_i | input | COL_W | Starting column |
| blen_i | input | 3 | Burst length code |
| wrap_il_i | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_single_i | input | 1 | Single-beat write option |
| is_write_i | input | 1 | Access is a write |
| org_i | input | 2 | Device organisation selector |
| stop_i | input | 1 | End the active burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Every output is registered once after the sampling edge. Beat 0 is therefore visible in the cycle after the edge that sees `start_i`, and beat k is visible k cycles after that. A stop, or the end after `last_o`, clears `valid_o` one cycle after the edge that samples it. The bench model updates on the same rising edge as the design and compares all three outputs at the falling edge of every cycle, so each result is checked in the cycle it is due and never before.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
   typedef enum logic [1:0] {
      ORG_X4   = 2'd0,
      ORG_X8   = 2'd1,
      ORG_X16  = 2'd2,
      ORG_X16B = 2'd3
   } org_e;

   localparam logic [2:0] BLC_1    = 3'd0;
   localparam logic [2:0] BLC_2    = 3'd1;
   localparam logic [2:0] BLC_4    = 3'd2;
   localparam logic [2:0] BLC_8    = 3'd3;
   localparam logic [2:0] BLC_PAGE = 3'd7;
endpackage

// File: rtl/sdram_col_len_dec.sv
module sdram_col_len_dec
   import sdram_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [2:0]       blen_i,
   input  logic [1:0]       org_i,
   input  logic             force_one_i,
   output logic [COL_W-1:0] page_mask_o,
   output logic [COL_W-1:0] span_mask_o,
   output logic             full_o
);
   // Column bits that exist for the selected organisation.
   for (genvar i = 0; i < COL_W; i++) begin : g_page
      if (i < COL_W - 2) begin : g_always
         assign page_mask_o[i] = 1'b1;
      end else if (i == COL_W - 2) begin : g_x8_top
         assign page_mask_o[i] = (org_i == ORG_X4) || (org_i == ORG_X8);
      end else begin : g_x4_top
         assign page_mask_o[i] = (org_i == ORG_X4);
      end
   end

   always_comb begin
      span_mask_o = '0;
      full_o      = 1'b0;
      if (!force_one_i) begin
         unique case (blen_i)
            BLC_2:    span_mask_o = COL_W'(1);
            BLC_4:    span_mask_o = COL_W'(3);
            BLC_8:    span_mask_o = COL_W'(7);
            BLC_PAGE: begin
               span_mask_o = page_mask_o;
               full_o      = 1'b1;
            end
            default:  span_mask_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/sdram_col_addr.sv
module sdram_col_addr #(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] start_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] span_i,
   input  logic             il_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] il_low;

   assign seq_low = start_i + beat_i;
   assign il_low  = start_i ^ beat_i;
   assign col_o   = (start_i & ~span_i) | ((il_i ? il_low : seq_low) & span_i);
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
   import sdram_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       blen_i,
   input  logic             wrap_il_i,
   input  logic             wr_single_i,
   input  logic             is_write_i,
   input  logic [1:0]       org_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   if (COL_W < 5) begin : g_bad_width
      $error("sdram_col_gen: COL_W must be at least 5");
   end

   logic [COL_W-1:0] page_mask, span_mask, cur_col;
   logic             full_sel;
   logic [COL_W-1:0] start_q, beat_q, span_q;
   logic             il_q, full_q, valid_q, last_q;
   logic [COL_W-1:0] beat_nx;

   sdram_col_len_dec #(.COL_W(COL_W)) u_len (
      .blen_i      (blen_i),
      .org_i       (org_i),
      .force_one_i (wr_single_i && is_write_i),
      .page_mask_o (page_mask),
      .span_mask_o (span_mask),
      .full_o      (full_sel)
   );

   sdram_col_addr #(.COL_W(COL_W)) u_addr (
      .start_i (start_q),
      .beat_i  (beat_q),
      .span_i  (span_q),
      .il_i    (il_q),
      .col_o   (cur_col)
   );

   assign beat_nx = (beat_q + ONE) & span_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         beat_q  <= '0;
         span_q  <= '0;
         il_q    <= 1'b0;
         full_q  <= 1'b0;
         valid_q <= 1'b0;
         last_q  <= 1'b0;
      end else if (start_i) begin
         start_q <= start_col_i & page_mask;
         beat_q  <= '0;
         span_q  <= span_mask;
         il_q    <= wrap_il_i && !full_sel;
         full_q  <= full_sel;
         valid_q <= 1'b1;
         last_q  <= (span_mask == '0) && !full_sel;
      end else if (valid_q) begin
         if (stop_i || last_q) begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
         end else begin
            beat_q <= beat_nx;
            last_q <= (beat_nx == span_q) && !full_q;
         end
      end
   end

   assign col_o   = valid_q ? cur_col : '0;
   assign valid_o = valid_q;
   assign last_o  = last_q;
endmodule

module sdram_col_gen_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       blen_i,
   input logic             wrap_il_i,
   input logic             wr_single_i,
   input logic             is_write_i,
   input logic [1:0]       org_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);
   assert_start_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);

   assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && wr_single_i && is_write_i) |=> last_o);

   assert_x16_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && org_i[1]) |=> (col_o[COL_W-1 -: 2] == 2'b00));

   assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (!valid_o && !last_o));

   always_comb begin
      if (rst_n && !valid_o) begin
         assert_idle_quiet_R10: assert (col_o == '0 && !last_o);
      end
   end
endmodule

bind sdram_col_gen sdram_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_col_gen_bench.sv
module sdram_col_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int COL_W      = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       blen_i = '0;
   logic             wrap_il_i = 1'b0;
   logic             wr_single_i = 1'b0;
   logic             is_write_i = 1'b0;
   logic [1:0]       org_i = '0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o, last_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R10";

   sdram_col_gen #(.COL_W(COL_W)) u_sdram_col_gen (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   bit m_valid, m_full, m_il;
   int m_start, m_bl, m_beat, m_pg;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_beat = 0;
      end else if (start_i) begin
         m_pg = (org_i == 0) ? 1024 : (org_i == 1) ? 512 : 256;
         m_start = int'(start_col_i) % m_pg;
         m_full = 0;
         case (blen_i)
            3'd1: m_bl = 2;
            3'd2: m_bl = 4;
            3'd3: m_bl = 8;
            3'd7: begin m_bl = m_pg; m_full = 1; end
            default: m_bl = 1;
         endcase
         if (wr_single_i && is_write_i) begin m_bl = 1; m_full = 0; end
         m_il = wrap_il_i && !m_full;
         m_beat = 0;
         m_valid = 1;
      end else if (m_valid) begin
         if (stop_i || (!m_full && m_beat == m_bl - 1)) m_valid = 0;
         else m_beat++;
      end
   end

   function automatic int exp_col();
      int base, off;
      if (!m_valid) return 0;
      if (m_full) return (m_start + m_beat) % m_pg;
      base = m_start - (m_start % m_bl);
      off  = m_start % m_bl;
      if (m_il) return base + (off ^ m_beat);
      return base + ((off + m_beat) % m_bl);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         int ec;
         bit el;
         ec = exp_col();
         el = m_valid && !m_full && (m_beat == m_bl - 1);
         checks++;
         if (valid_o !== m_valid || last_o !== el || int'(col_o) != ec) begin
            errors++;
            $display("FAIL %s: valid/last/col got %0b/%0b/%0h expected %0b/%0b/%0h",
                     cur_req, valid_o, last_o, col_o, m_valid, el, ec);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic go(input string tag, input int col, input int bl, input bit il,
                     input bit ws, input bit wr, input int org, input int idle_n);
      @(negedge clk);
      cur_req = tag;
      start_i = 1; start_col_i = COL_W'(col); blen_i = 3'(bl); wrap_il_i = il;
      wr_single_i = ws; is_write_i = wr; org_i = 2'(org);
      @(negedge clk);
      start_i = 0;
      repeat (idle_n) @(negedge clk);
   endtask

   task automatic stop_now(input int idle_n);
      stop_i = 1;
      @(negedge clk);
      stop_i = 0;
      repeat (idle_n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== '0) begin
         errors++;
         $display("FAIL R10 reset: got %0b/%0b/%0h expected 0/0/0", valid_o, last_o, col_o);
      end
      rst_n = 1;
      @(negedge clk);
      go("R2", 'h0A6, 2, 0, 0, 0, 0, 5);
      go("R2", 'h3FD, 3, 0, 0, 0, 0, 9);
      go("R2", 'h011, 1, 0, 0, 0, 0, 3);
      go("R5", 'h155, 0, 0, 0, 0, 0, 2);
      go("R3", 'h0A5, 3, 1, 0, 0, 0, 9);
      go("R3", 'h1F2, 2, 1, 0, 0, 0, 5);
      go("R4", 'h3FC, 7, 0, 0, 0, 0, 8);
      stop_now(2);
      go("R4", 'h0F0, 7, 1, 0, 0, 1, 5);
      stop_now(2);
      go("R7", 'h2FD, 7, 0, 0, 0, 2, 6);
      stop_now(2);
      go("R7", 'h3FF, 3, 0, 0, 0, 1, 9);
      go("R7", 'h3FB, 2, 1, 0, 0, 3, 5);
      go("R6", 'h120, 3, 0, 1, 1, 0, 3);
      go("R6", 'h120, 3, 0, 1, 0, 0, 9);
      go("R6", 'h12A, 2, 0, 0, 1, 0, 5);
      go("R6", 'h12A, 7, 0, 1, 1, 0, 3);
      go("R11", 'h077, 5, 0, 0, 0, 0, 2);
      go("R11", 'h078, 4, 1, 0, 0, 0, 2);
      go("R11", 'h079, 6, 0, 0, 0, 0, 2);
      go("R8", 'h200, 3, 0, 0, 0, 0, 2);
      go("R8", 'h30E, 2, 1, 0, 0, 0, 0);
      go("R8", 'h045, 1, 0, 0, 0, 0, 4);
      go("R9", 'h100, 3, 0, 0, 0, 0, 2);
      stop_now(3);
      go("R1", 'h1FF, 1, 0, 0, 0, 0, 0);
      go("R1", 'h000, 7, 0, 0, 0, 0, 1030);
      stop_now(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule